// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. The framing can be changed at run time: data length of 5 to 8 bits, no parity, computed even or odd parity, or a fixed (stick) parity bit, and one or two stop bits. A smartcard-mode input forces two stop bits. A send-break control holds the line low, but only once the character being shifted has fully left the shifter. Bytes enter through a valid/ready port into a small buffer. With buffering mode off, the buffer is a one-character holding register. With buffering mode on, it holds `FIFO_DEPTH` characters. An external 16x oversampling enable, `baud_tick`, paces every bit.

A state machine sequences each frame. The states are IDLE, START, DATA, PARITY, STOP, BREAK and GAP. The transitions are as follows:
- IDLE goes to BREAK when break is requested. Break takes priority over any character in the buffer.
- IDLE otherwise goes to START when the buffer holds a character. On this move the machine pops the character and latches the framing inputs.
- START goes to DATA after one bit time.
- DATA goes to PARITY after the last data bit if parity is enabled, and to STOP if it is not.
- PARITY goes to STOP after one bit time.
- STOP repeats once if two stop bits were latched.
- At the end of the final stop bit, STOP goes to BREAK if break is requested, and to IDLE if it is not.
- BREAK goes to GAP when break is released.
- GAP goes to IDLE after one full bit time at the high level.

Top module: `uart_frame_tx`

## Requirements
- R1: The length code `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are sent LSB first. Code 0 is the expected setting after reset.
- R2: With `cfg_par_en`=0, the stop bit follows the last data bit directly, and no parity bit is sent.
- R3: With `cfg_par_en`=1 and `cfg_stick`=0, the parity bit makes the count of ones over data and parity even when `cfg_even`=1, and odd when `cfg_even`=0.
- R4: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit is 0 when `cfg_even`=1 and 1 when `cfg_even`=0, whatever the data.
- R5: One stop bit (high) is sent when `cfg_two_stop`=0, and two when it is 1. While `smartcard`=1, two stop bits are sent regardless of `cfg_two_stop`.
- R6: While `send_break`=1, the line is held low continuously. A break raised mid-frame starts only after the frame's last stop bit. Break takes priority over a buffered character, and the low level lasts as long as `send_break` stays 1.
- R7: `in_ready` is 1 exactly when the buffer holds fewer characters than its capacity. The capacity is 1 when `fifo_en`=0 and `FIFO_DEPTH` when `fifo_en`=1. Characters leave the buffer in arrival order.
- R8: The line idles high, and the start bit is low. Every bit lasts `TICKS_PER_BIT` (16) `baud_tick` pulses, ending on the 16th pulse. In IDLE with a character buffered and no break requested, the start bit begins on the next clock.
- R9: The framing inputs are sampled at the start of each frame. A change during a frame affects only later frames.
- R10: After break is released, the line is high for one full bit time before any start bit.
- R11: During and after reset, `tx`=1, `in_ready`=1 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | 16x oversampling enable pulse |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character value |
| in_ready | output | 1 | Buffer can accept a character |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select / stick value select |
| cfg_stick | input | 1 | Stick parity |
| cfg_two_stop | input | 1 | Two stop bits |
| smartcard | input | 1 | Forces two stop bits |
| fifo_en | input | 1 | Buffer capacity FIFO_DEPTH instead of 1 |
| send_break | input | 1 | Hold line low after the current frame |
| tx | output | 1 | Serial line |

## Verification
The assertions check the following on every cycle:
- Framing values stay fixed for the whole of a frame.
- A start bit is entered only from idle.
- The data bit index never passes the latched length.
- A latched two-stop frame always ends after its second stop bit.
- Break is entered only from idle or at the end of a stop bit.
- Leaving break always passes through the high gap.
- The holding register never holds two characters.

Only the bench's scenarios can show the rest. These are the actual line values: parity polarity for each mode, LSB-first order and bit timing. They also cover the smartcard override, the effect of a mid-frame configuration change, and break priority over a queued character. The bench compares the line and `in_ready` with a behavioural model on every clock.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int UFTX_DW       = 8;
    localparam int UFTX_MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_GAP
    } uftx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       even;
        logic       stick;
        logic       two_stop;
    } uftx_cfg_t;

endpackage

// File: rtl/uftx_buf.sv
module uftx_buf #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          not_empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count, cap;
    logic          do_push, do_pop;

    assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
    assign push_ready = count < cap;
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && (count != '0);
    assign not_empty  = count != '0;
    assign head_data  = mem[rp];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wrap_inc(wp);
            if (do_pop)  rp <= wrap_inc(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $past(!fifo_en) && $past(count) <= CW'(1)) |-> (count <= CW'(1))); // R7

endmodule

// File: rtl/uftx_par.sv
module uftx_par
    import uftx_pkg::*;
(
    input  logic [UFTX_DW-1:0] data,
    input  uftx_cfg_t          cfg,
    output logic               par_bit
);

    logic ones_odd;

    always_comb begin
        ones_odd = 1'b0;
        for (int i = 0; i < UFTX_DW; i++) begin
            if (i < int'(cfg.len) + UFTX_MIN_BITS) ones_odd = ones_odd ^ data[i];
        end
        if (cfg.stick) par_bit = ~cfg.even;
        else if (cfg.even) par_bit = ones_odd;
        else par_bit = ~ones_odd;
    end

endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
    import uftx_pkg::*;
#(
    parameter int TPB = 16,
    localparam int CTW = (TPB > 1) ? $clog2(TPB) : 1,
    localparam int IW  = $clog2(UFTX_DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  uftx_cfg_t          cfg_in,
    input  logic               brk,
    input  logic               have_data,
    input  logic [UFTX_DW-1:0] head_data,
    input  logic               par_in,
    output logic               pop,
    output logic               tx
);

    uftx_state_e        state, state_nx;
    uftx_cfg_t          cfg_q;
    logic [CTW-1:0]     cnt;
    logic [IW-1:0]      bit_idx;
    logic               stop_idx;
    logic [UFTX_DW-1:0] sh;
    logic               par_q;
    logic               bit_end, last_data, more_stop;

    assign bit_end   = tick && (int'(cnt) == TPB - 1);
    assign last_data = int'(bit_idx) == int'(cfg_q.len) + UFTX_MIN_BITS - 1;
    assign more_stop = cfg_q.two_stop && !stop_idx;
    assign pop       = (state == ST_IDLE) && !brk && have_data;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (brk) state_nx = ST_BREAK;
                       else if (have_data) state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP:   if (bit_end && !more_stop) state_nx = brk ? ST_BREAK : ST_IDLE;
            ST_BREAK:  if (!brk) state_nx = ST_GAP;
            ST_GAP:    if (bit_end) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cfg_q    <= '0;
            cnt      <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            sh       <= '0;
            par_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE || state == ST_BREAK) cnt <= '0;
            else if (tick) cnt <= bit_end ? '0 : cnt + CTW'(1);
            if (pop) begin
                cfg_q    <= cfg_in;
                sh       <= head_data;
                par_q    <= par_in;
                stop_idx <= 1'b0;
            end
            if (state == ST_START && bit_end) bit_idx <= '0;
            if (state == ST_DATA && bit_end) begin
                sh      <= sh >> 1;
                bit_idx <= bit_idx + IW'(1);
            end
            if (state == ST_STOP && bit_end) stop_idx <= more_stop;
        end
    end

    always_comb begin
        unique case (state)
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = sh[0];
            ST_PARITY: tx = par_q;
            ST_BREAK:  tx = 1'b0;
            default:   tx = 1'b1;
        endcase
    end

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(cfg_q)); // R9
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> $past(state) == ST_IDLE); // R8
    AST_DATA_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (int'(bit_idx) <= int'(cfg_q.len) + UFTX_MIN_BITS - 1)); // R1
    AST_SECOND_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STOP && $past(state) == ST_STOP && $past(cfg_q.two_stop)) |-> $past(stop_idx)); // R5
    AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK && $past(state) != ST_BREAK)
            |-> ($past(state) == ST_IDLE || $past(state) == ST_STOP)); // R6
    AST_GAP_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BREAK && $past(state) == ST_BREAK) |-> state == ST_GAP); // R10

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int FIFO_DEPTH    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_even,
    input  logic       cfg_stick,
    input  logic       cfg_two_stop,
    input  logic       smartcard,
    input  logic       fifo_en,
    input  logic       send_break,
    output logic       tx
);

    uftx_cfg_t          cfg_live;
    logic [UFTX_DW-1:0] head_data;
    logic               have_data, pop, par_bit;

    assign cfg_live = '{len: cfg_len, par_en: cfg_par_en, even: cfg_even,
                        stick: cfg_stick, two_stop: cfg_two_stop | smartcard};

    uftx_buf #(.DEPTH(FIFO_DEPTH), .DW(UFTX_DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
        .pop(pop), .head_data(head_data), .not_empty(have_data)
    );

    uftx_par u_par (.data(head_data), .cfg(cfg_live), .par_bit(par_bit));

    uftx_seq #(.TPB(TICKS_PER_BIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg_in(cfg_live),
        .brk(send_break), .have_data(have_data), .head_data(head_data),
        .par_in(par_bit), .pop(pop), .tx(tx)
    );

endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

    localparam int DEPTH = 4;
    localparam int TPB   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0, smartcard = 1'b0, fifo_en = 1'b0;
    logic       send_break = 1'b0;
    logic       tx;

    uart_frame_tx #(.TICKS_PER_BIT(TPB), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_even(cfg_even), .cfg_stick(cfg_stick),
        .cfg_two_stop(cfg_two_stop), .smartcard(smartcard), .fifo_en(fifo_en),
        .send_break(send_break), .tx(tx)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R11";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle 1 start 2 data 3 parity 4 stop 5 break 6 gap
    byte unsigned m_q[$];
    int  ms = 0, mc = 0, mb = 0, mstop = 0;
    int  m_nbits = 5, m_pen = 0, m_two = 0, m_par = 0;
    byte unsigned m_data = 0;

    function automatic int exp_tx();
        case (ms)
            1: return 0;
            2: return int'(m_data[mb]);
            3: return m_par;
            5: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_ready();
        return (m_q.size() < (fifo_en ? DEPTH : 1)) ? 1 : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.delete();
            ms = 0; mc = 0; mb = 0; mstop = 0;
        end else begin
            int sz;
            bit adv;
            sz = m_q.size();
            adv = 1'b0;
            case (ms)
                0: begin
                    if (send_break) ms = 5;
                    else if (sz > 0) begin
                        int ones;
                        m_data  = m_q.pop_front();
                        m_nbits = int'(cfg_len) + 5;
                        m_pen   = cfg_par_en;
                        m_two   = cfg_two_stop || smartcard;
                        ones = 0;
                        for (int i = 0; i < m_nbits; i++) ones += m_data[i];
                        if (cfg_stick) m_par = cfg_even ? 0 : 1;
                        else m_par = cfg_even ? (ones % 2) : 1 - (ones % 2);
                        ms = 1; mc = 0; mstop = 0;
                    end
                end
                1, 2, 3, 4, 6: begin
                    if (baud_tick) begin
                        if (mc == TPB - 1) begin mc = 0; adv = 1'b1; end
                        else mc++;
                    end
                end
                5: if (!send_break) begin ms = 6; mc = 0; end
                default: ms = 0;
            endcase
            if (adv) begin
                case (ms)
                    1: begin ms = 2; mb = 0; end
                    2: if (mb == m_nbits - 1) ms = m_pen ? 3 : 4; else mb++;
                    3: ms = 4;
                    4: if (mstop == 0 && m_two) mstop = 1;
                       else ms = send_break ? 5 : 0;
                    6: ms = 0;
                    default: ms = 0;
                endcase
            end
            if (in_valid && sz < (fifo_en ? DEPTH : 1)) m_q.push_back(in_data);
        end
    end

    // tick generator: one pulse every third clock
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 0);
    end

    // per-cycle comparison against the model, away from clock edges
    always @(negedge clk) begin
        #5;
        if (cmp_on && !done) begin
            chk(tx == exp_tx(), cur_req, int'(tx), exp_tx());
            chk(in_ready == exp_ready(), cur_req, int'(in_ready), exp_ready());
        end
    end

    task automatic send(input byte unsigned b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #6;
        while (!in_ready) begin
            @(negedge clk);
            #6;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int lim = 0;
        do begin
            @(negedge clk);
            lim++;
        end while (!(ms == 0 && m_q.size() == 0) && lim < 20000);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int len, input bit pen, input bit even,
                           input bit stick, input bit two, input bit sc);
        @(negedge clk);
        cfg_len = 2'(len); cfg_par_en = pen; cfg_even = even;
        cfg_stick = stick; cfg_two_stop = two; smartcard = sc;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #6;
        chk(tx == 1'b1, "R11", int'(tx), 1);
        chk(in_ready == 1'b1, "R11", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (4) @(negedge clk);

        cur_req = "R8";   set_cfg(0, 0, 0, 0, 0, 0); send(8'h15); wait_idle();
        cur_req = "R1";   set_cfg(1, 0, 0, 0, 0, 0); send(8'h2B); wait_idle();
                          set_cfg(2, 0, 0, 0, 0, 0); send(8'h4E); wait_idle();
                          set_cfg(3, 0, 0, 0, 0, 0); send(8'hB1); wait_idle();
        cur_req = "R2";   set_cfg(3, 0, 1, 0, 0, 0); send(8'hFF); wait_idle();
        cur_req = "R3";   set_cfg(3, 1, 1, 0, 0, 0); send(8'hA5); wait_idle();
                          set_cfg(3, 1, 0, 0, 0, 0); send(8'hA5); wait_idle();
                          set_cfg(0, 1, 1, 0, 0, 0); send(8'hE1); wait_idle();
                          set_cfg(2, 1, 0, 0, 0, 0); send(8'h07); wait_idle();
        cur_req = "R4";   set_cfg(3, 1, 1, 1, 0, 0); send(8'h01); wait_idle();
                          set_cfg(3, 1, 0, 1, 0, 0); send(8'h03); wait_idle();
        cur_req = "R5";   set_cfg(1, 0, 0, 0, 1, 0); send(8'h3C); wait_idle();
                          set_cfg(1, 1, 1, 0, 0, 1); send(8'h15); wait_idle();

        cur_req = "R9";
        set_cfg(3, 1, 1, 0, 0, 0);
        send(8'hC3);
        send(8'h5A);
        repeat (100) @(negedge clk);
        cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        wait_idle();

        cur_req = "R7";
        set_cfg(3, 0, 0, 0, 0, 0);
        fifo_en = 1'b0;
        send(8'h11);
        send(8'h22);
        #6;
        chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
        wait_idle();
        fifo_en = 1'b1;
        for (int k = 0; k < DEPTH + 1; k++) send(8'h30 + 8'(k));
        #6;
        chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
        wait_idle();
        fifo_en = 1'b0;

        cur_req = "R6";
        set_cfg(3, 1, 0, 0, 1, 0);
        send(8'h96);
        send(8'h69);
        repeat (80) @(negedge clk);
        send_break = 1'b1;
        repeat (1500) @(negedge clk);
        #6;
        chk(tx == 1'b0, "R6", int'(tx), 0);
        @(negedge clk);
        cur_req = "R10";
        send_break = 1'b0;
        repeat (20) @(negedge clk);
        #6;
        chk(tx == 1'b1, "R10", int'(tx), 1);
        wait_idle();

        cur_req = "R6";
        send_break = 1'b1;
        repeat (30) @(negedge clk);
        #6;
        chk(tx == 1'b0, "R6", int'(tx), 0);
        @(negedge clk);
        send_break = 1'b0;
        cur_req = "R10";
        wait_idle();

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule